// File: doc/BRIEF.md
# Radio Command Strobe Sequencer

This block runs short byte-coded command programs that steer a radio transceiver. A host loads opcodes one byte at a time into a small program store and then starts execution. The sequencer steps through the store at one instruction per clock. It keeps three 8-bit counters (X, Y, Z) and a loop label. It can stall on timer overflow ticks or on either of two timer event inputs. It can skip ahead or branch back on one of eight conditions. It emits single-cycle command pulses toward the radio, a set-compare pulse toward the timer, and an interrupt pulse.

The host can also issue immediate opcodes. These act at once and leave the program store alone. They fire radio pulses, start or stop the program, or empty the store. The radio, the timer and the random source are outside the block and appear only as input pins.

Top module: `strobe_seq`

## Requirements
- R1: After reset `running`, `pc`, `radioStrobe`, `irq`, `setCmp`, `sampledCca` and the three counters are all zero.
- R2: A host write with `hostImm` low appends the byte at the write pointer. The store holds 24 bytes, and further appends are dropped. Immediate 0xFF empties the store, returns `pc` to 0 and stops execution.
- R3: Immediate 0xE1 starts execution at address 0. Immediate 0xE2 stops execution and abandons any pending wait. Opcode 0xD2 halts with `pc` left on it. `running` goes low once `pc` reaches the write pointer.
- R4: Opcodes 0xC0/0xC1/0xC2 add one to X/Y/Z and 0xC3/0xC4/0xC5 subtract one, wrapping modulo 256. Immediate opcodes never change the counters.
- R5: Opcode 0xC8|M (M in 0..7) adds one to Y only while Y < M. Opcode 0xBD copies `rndIn` into X.
- R6: Opcode 0x80|W (W in 0..31) stalls until W `timerOvf` ticks have been seen after the wait began. Opcode 0xBC stalls for X ticks. A count of zero takes one cycle. While stalled, `pc` already points past the wait.
- R7: Opcode 0xB8 stalls until `timerEv1` and 0xB9 until `timerEv2`. The other event has no effect.
- R8: Opcode 0xBB stores the next address as the label. Opcode 0xA0|N<<3|C jumps to the label when condition C, inverted if N=1, is true, and otherwise falls through.
- R9: Opcode S<<4|N<<3|C (bit 7 clear) skips the next S instructions when the optionally inverted condition holds. The condition codes are: 0 `ccaIn`, 1 `sampledCca`, 2 `rxActive`, 3 `txActive`, 4 X==0, 5 Y==0, 6 Z==0, 7 true.
- R10: A stored opcode 0xD0|k pulses `radioStrobe[k]` for one cycle, one cycle after it executes, for k in {3,4,5,6,7,8,9,D,E,F}. Immediate 0xE0|k (k from 3 to F) behaves the same as 0xD0|k. Bits 0,1,2,A,B,C never pulse.
- R11: Opcode k=A (0xDA or 0xEA) pulses `radioStrobe[9]` only when `ccaIn` is high. Opcode k=B (0xDB or 0xEB) copies `ccaIn` into `sampledCca`.
- R12: Opcode 0xBA pulses `irq` and 0xBE pulses `setCmp` for one cycle, one cycle after execution.
- R13: An immediate radio opcode that arrives in the same cycle as a program instruction adds its pulse to that instruction's, and both take effect. An immediate start, stop or clear in that cycle suppresses the program instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host byte write strobe |
| hostImm | input | 1 | 1: byte is an immediate opcode, 0: append to store |
| hostData | input | 8 | Host opcode byte |
| timerOvf | input | 1 | Timer overflow tick |
| timerEv1 | input | 1 | Timer event 1 |
| timerEv2 | input | 1 | Timer event 2 |
| ccaIn | input | 1 | Clear-channel indication |
| rxActive | input | 1 | Radio receiving |
| txActive | input | 1 | Radio transmitting |
| rndIn | input | CNT_W | Random value source |
| radioStrobe | output | 16 | One-hot radio command pulses, bit k for 0xD0\|k |
| setCmp | output | 1 | Capture-timer pulse |
| irq | output | 1 | Interrupt pulse |
| sampledCca | output | 1 | Sampled clear-channel bit |
| running | output | 1 | Program executing or stalled |
| pc | output | PC_W | Program counter |
| cntX | output | CNT_W | X counter |
| cntY | output | CNT_W | Y counter |
| cntZ | output | CNT_W | Z counter |

## Verification
The two functions that can share a cycle are the host's immediate path and the stored program's execution. The bench starts a stored run of radio opcodes and presents an immediate radio opcode in the host cycle that lines up with the first stored instruction. It then expects the union of both pulse bits, followed by the stored instruction's pulse alone. A second run presents an immediate stop in that same cycle and expects no pulse, `pc` still at 0 and `running` low.

// File: rtl/strobe_seq_pkg.sv
`timescale 1ns/1ps
package strobe_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_TICK = 2'd1,
    ST_EV1  = 2'd2,
    ST_EV2  = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       incX;
    logic       incY;
    logic       incZ;
    logic       decX;
    logic       decY;
    logic       decZ;
    logic       incMaxY;
    logic [2:0] maxY;
    logic       loadRnd;
    logic       sampleCca;
  } dpCmd_t;

  localparam logic [7:0] OP_START = 8'hE1;
  localparam logic [7:0] OP_STOP  = 8'hE2;
  localparam logic [7:0] OP_CLEAR = 8'hFF;

  // low nibble of a radio opcode to its one-hot pulse vector
  function automatic logic [15:0] strobeMap(input logic [3:0] lo, input logic chanClear);
    logic [15:0] v;
    v = '0;
    case (lo)
      4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9,
      4'hD, 4'hE, 4'hF: v[lo] = 1'b1;
      4'hA:             v[9]  = chanClear;
      default:          v     = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/seq_prog_mem.sv
`timescale 1ns/1ps
module seq_prog_mem #(
  parameter int DEPTH = 24,
  parameter int PC_W  = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            clear,
  input  logic [7:0]      wrData,
  input  logic [PC_W-1:0] rdAddr,
  output logic [7:0]      rdData,
  output logic [PC_W-1:0] wrPtr
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [7:0] slot [DEPTH];
  logic       hasRoom;

  assign hasRoom = wrPtr < PC_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (clear) begin
      wrPtr <= '0;
    end else if (wrEn && hasRoom) begin
      wrPtr <= wrPtr + PC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn && hasRoom) slot[wrPtr[IDX_W-1:0]] <= wrData;
  end

  always_comb begin
    if (rdAddr < PC_W'(DEPTH)) rdData = slot[rdAddr[IDX_W-1:0]];
    else                       rdData = 8'hD0;
  end
endmodule

// File: rtl/seq_datapath.sv
`timescale 1ns/1ps
module seq_datapath
  import strobe_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic             ccaIn,
  input  logic             rxActive,
  input  logic             txActive,
  input  logic [CNT_W-1:0] rndIn,
  output logic [CNT_W-1:0] cntX,
  output logic [CNT_W-1:0] cntY,
  output logic [CNT_W-1:0] cntZ,
  output logic             sampledCca,
  output logic [7:0]       condVec
);
  logic yBelowMax;

  assign yBelowMax = cntY < CNT_W'(cmd.maxY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntX       <= '0;
      cntY       <= '0;
      cntZ       <= '0;
      sampledCca <= 1'b0;
    end else begin
      if (cmd.loadRnd)   cntX <= rndIn;
      else if (cmd.incX) cntX <= cntX + CNT_W'(1);
      else if (cmd.decX) cntX <= cntX - CNT_W'(1);

      if (cmd.incY || (cmd.incMaxY && yBelowMax)) cntY <= cntY + CNT_W'(1);
      else if (cmd.decY)                           cntY <= cntY - CNT_W'(1);

      if (cmd.incZ)      cntZ <= cntZ + CNT_W'(1);
      else if (cmd.decZ) cntZ <= cntZ - CNT_W'(1);

      if (cmd.sampleCca) sampledCca <= ccaIn;
    end
  end

  always_comb begin
    condVec[0] = ccaIn;
    condVec[1] = sampledCca;
    condVec[2] = rxActive;
    condVec[3] = txActive;
    condVec[4] = (cntX == '0);
    condVec[5] = (cntY == '0);
    condVec[6] = (cntZ == '0);
    condVec[7] = 1'b1;
  end
endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
  import strobe_seq_pkg::*;
#(
  parameter int PC_W  = 5,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic             hostImm,
  input  logic [7:0]       hostData,
  input  logic [7:0]       instr,
  input  logic [PC_W-1:0]  wrPtr,
  input  logic [7:0]       condVec,
  input  logic [CNT_W-1:0] xVal,
  input  logic             timerOvf,
  input  logic             timerEv1,
  input  logic             timerEv2,
  input  logic             ccaIn,
  output logic [PC_W-1:0]  pc,
  output logic             running,
  output dpCmd_t           dpCmd,
  output logic             memWrEn,
  output logic             memClear,
  output logic [15:0]      radioStrobe,
  output logic             irq,
  output logic             setCmp
);
  seqState_e        state, goState;
  logic             runFlag;
  logic [PC_W-1:0]  label, pcStep, jumpPc;
  logic [CNT_W-1:0] waitCnt, waitVal;
  logic             immCmd, immStart, immStop, immClear, immCtl, immRadio;
  logic             pcLive, waiting, progGo, cond;
  logic             loadWait, labelHit, halt, progIrq, progCmp;
  logic [15:0]      progStrb, immStrb;

  // host side
  assign immCmd   = hostWrEn & hostImm;
  assign memWrEn  = hostWrEn & ~hostImm;
  assign immStart = immCmd && (hostData == OP_START);
  assign immStop  = immCmd && (hostData == OP_STOP);
  assign immClear = immCmd && (hostData == OP_CLEAR);
  assign immCtl   = immStart | immStop | immClear;
  assign memClear = immClear;
  assign immRadio = immCmd && (hostData[7:4] == 4'hE) && (hostData[3:0] >= 4'h3);
  assign immStrb  = immRadio ? strobeMap(hostData[3:0], ccaIn) : '0;

  // sequencing status
  assign pcLive  = pc < wrPtr;
  assign waiting = (state != ST_RUN);
  assign running = runFlag && (waiting || pcLive);
  assign progGo  = runFlag && !waiting && pcLive && !immCtl;
  assign cond    = condVec[instr[2:0]] ^ instr[3];
  assign pcStep  = pc + PC_W'(1);

  // instruction decode
  always_comb begin
    dpCmd    = '0;
    progStrb = '0;
    progIrq  = 1'b0;
    progCmp  = 1'b0;
    halt     = 1'b0;
    labelHit = 1'b0;
    loadWait = 1'b0;
    waitVal  = '0;
    jumpPc   = pcStep;
    goState  = ST_RUN;
    if (progGo) begin
      casez (instr)
        8'b0???????: if (cond) jumpPc = pcStep + PC_W'(instr[6:4]);
        8'b100?????: begin
          loadWait = 1'b1;
          waitVal  = CNT_W'(instr[4:0]);
        end
        8'b1010????: if (cond) jumpPc = label;
        8'hB8: goState  = ST_EV1;
        8'hB9: goState  = ST_EV2;
        8'hBA: progIrq  = 1'b1;
        8'hBB: labelHit = 1'b1;
        8'hBC: begin
          loadWait = 1'b1;
          waitVal  = xVal;
        end
        8'hBD: dpCmd.loadRnd = 1'b1;
        8'hBE: progCmp       = 1'b1;
        8'hC0: dpCmd.incX    = 1'b1;
        8'hC1: dpCmd.incY    = 1'b1;
        8'hC2: dpCmd.incZ    = 1'b1;
        8'hC3: dpCmd.decX    = 1'b1;
        8'hC4: dpCmd.decY    = 1'b1;
        8'hC5: dpCmd.decZ    = 1'b1;
        8'b11001???: begin
          dpCmd.incMaxY = 1'b1;
          dpCmd.maxY    = instr[2:0];
        end
        8'hD2: halt = 1'b1;
        8'b1101????: begin
          progStrb = strobeMap(instr[3:0], ccaIn);
          if (instr[3:0] == 4'hB) dpCmd.sampleCca = 1'b1;
        end
        default: halt = 1'b0;
      endcase
      if (loadWait && (waitVal != '0)) goState = ST_TICK;
    end
    if (immRadio && (hostData[3:0] == 4'hB)) dpCmd.sampleCca = 1'b1;
  end

  // output pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      radioStrobe <= '0;
      irq         <= 1'b0;
      setCmp      <= 1'b0;
    end else begin
      radioStrobe <= progStrb | immStrb;
      irq         <= progIrq;
      setCmp      <= progCmp;
    end
  end

  // program counter, waits and run flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= '0;
      label   <= '0;
      runFlag <= 1'b0;
      state   <= ST_RUN;
      waitCnt <= '0;
    end else if (immClear) begin
      pc      <= '0;
      label   <= '0;
      runFlag <= 1'b0;
      state   <= ST_RUN;
    end else if (immStart) begin
      pc      <= '0;
      runFlag <= 1'b1;
      state   <= ST_RUN;
    end else if (immStop) begin
      runFlag <= 1'b0;
      state   <= ST_RUN;
    end else if (runFlag) begin
      case (state)
        ST_RUN: begin
          if (!pcLive || halt) begin
            runFlag <= 1'b0;
          end else begin
            pc      <= jumpPc;
            state   <= goState;
            waitCnt <= waitVal;
            if (labelHit) label <= pcStep;
          end
        end
        ST_TICK: begin
          if (timerOvf) begin
            if (waitCnt == CNT_W'(1)) state <= ST_RUN;
            waitCnt <= waitCnt - CNT_W'(1);
          end
        end
        ST_EV1: if (timerEv1) state <= ST_RUN;
        ST_EV2: if (timerEv2) state <= ST_RUN;
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/strobe_seq.sv
`timescale 1ns/1ps
module strobe_seq
  import strobe_seq_pkg::*;
#(
  parameter  int PROG_DEPTH = 24,
  parameter  int CNT_W      = 8,
  localparam int PC_W       = $clog2(PROG_DEPTH + 8)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic             hostImm,
  input  logic [7:0]       hostData,
  input  logic             timerOvf,
  input  logic             timerEv1,
  input  logic             timerEv2,
  input  logic             ccaIn,
  input  logic             rxActive,
  input  logic             txActive,
  input  logic [CNT_W-1:0] rndIn,
  output logic [15:0]      radioStrobe,
  output logic             setCmp,
  output logic             irq,
  output logic             sampledCca,
  output logic             running,
  output logic [PC_W-1:0]  pc,
  output logic [CNT_W-1:0] cntX,
  output logic [CNT_W-1:0] cntY,
  output logic [CNT_W-1:0] cntZ
);
  dpCmd_t          dpCmd;
  logic [7:0]      instr;
  logic [7:0]      condVec;
  logic [PC_W-1:0] wrPtr;
  logic            memWrEn, memClear;

  seq_prog_mem #(.DEPTH(PROG_DEPTH), .PC_W(PC_W)) u_mem (
    .clk(clk), .rstN(rstN), .wrEn(memWrEn), .clear(memClear),
    .wrData(hostData), .rdAddr(pc), .rdData(instr), .wrPtr(wrPtr)
  );

  seq_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostImm(hostImm),
    .hostData(hostData), .instr(instr), .wrPtr(wrPtr), .condVec(condVec),
    .xVal(cntX), .timerOvf(timerOvf), .timerEv1(timerEv1), .timerEv2(timerEv2),
    .ccaIn(ccaIn), .pc(pc), .running(running), .dpCmd(dpCmd),
    .memWrEn(memWrEn), .memClear(memClear), .radioStrobe(radioStrobe),
    .irq(irq), .setCmp(setCmp)
  );

  seq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(dpCmd), .ccaIn(ccaIn), .rxActive(rxActive),
    .txActive(txActive), .rndIn(rndIn), .cntX(cntX), .cntY(cntY), .cntZ(cntZ),
    .sampledCca(sampledCca), .condVec(condVec)
  );
endmodule

// File: rtl/strobe_seq_chk.sv
`timescale 1ns/1ps
module strobe_seq_chk #(
  parameter  int PROG_DEPTH = 24,
  parameter  int CNT_W      = 8,
  localparam int PC_W       = $clog2(PROG_DEPTH + 8)
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostWrEn,
  input logic             hostImm,
  input logic [7:0]       hostData,
  input logic             ccaIn,
  input logic [15:0]      radioStrobe,
  input logic             irq,
  input logic             sampledCca,
  input logic             running,
  input logic [PC_W-1:0]  pc,
  input logic [CNT_W-1:0] cntX,
  input logic [CNT_W-1:0] cntY,
  input logic [CNT_W-1:0] cntZ
);
  logic immOp;
  assign immOp = hostWrEn && hostImm;

  a_r3_stop_ends_run: assert property (@(posedge clk) disable iff (!rstN)
    (immOp && hostData == 8'hE2) |=> !running);

  a_r3_start_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    (immOp && hostData == 8'hE1) |=> (pc == '0));

  a_r2_clear_rewinds: assert property (@(posedge clk) disable iff (!rstN)
    (immOp && hostData == 8'hFF) |=> (pc == '0 && !running));

  a_r11_sample_copies: assert property (@(posedge clk) disable iff (!rstN)
    (immOp && hostData == 8'hEB) |=> (sampledCca == $past(ccaIn)));

  a_r11_no_tx_on_busy: assert property (@(posedge clk) disable iff (!rstN)
    (immOp && hostData == 8'hEA && !ccaIn && !running) |=> !radioStrobe[9]);

  a_r12_irq_from_program: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(running));

  a_r4_imm_keeps_counters: assert property (@(posedge clk) disable iff (!rstN)
    (immOp && !running) |=> ($stable(cntX) && $stable(cntY) && $stable(cntZ)));
endmodule

bind strobe_seq strobe_seq_chk #(.PROG_DEPTH(PROG_DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/strobe_seq_bench.sv
`timescale 1ns/1ps
module strobe_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0, hostImm = 1'b0;
  logic [7:0]  hostData = 8'h00;
  logic        timerOvf = 1'b0, timerEv1 = 1'b0, timerEv2 = 1'b0;
  logic        ccaIn = 1'b0, rxActive = 1'b0, txActive = 1'b0;
  logic [7:0]  rndIn = 8'h00;
  logic [15:0] radioStrobe;
  logic        setCmp, irq, sampledCca, running;
  logic [4:0]  pc;
  logic [7:0]  cntX, cntY, cntZ;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  done    = 0;
  logic [7:0] prog [32];

  always #10 clk = ~clk;

  strobe_seq u_strobe_seq (.*);

  task automatic checkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hostPut(input logic imm, input logic [7:0] d);
    hostWrEn = 1'b1; hostImm = imm; hostData = d;
    @(negedge clk);
    hostWrEn = 1'b0; hostImm = 1'b0; hostData = 8'h00;
  endtask

  task automatic loadProg(input int n);
    hostPut(1'b1, 8'hFF);
    for (int i = 0; i < n; i++) hostPut(1'b0, prog[i]);
  endtask

  task automatic loadAndStart(input int n);
    loadProg(n);
    hostPut(1'b1, 8'hE1);
  endtask

  task automatic runToEnd(output logic sawIrq, output logic sawCmp);
    sawIrq = 1'b0; sawCmp = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      sawIrq |= irq;
      sawCmp |= setCmp;
      if (!running) break;
    end
  endtask

  task automatic pulse(input int which);
    if (which == 0) timerOvf = 1'b1;
    if (which == 1) timerEv1 = 1'b1;
    if (which == 2) timerEv2 = 1'b1;
    @(negedge clk);
    timerOvf = 1'b0; timerEv1 = 1'b0; timerEv2 = 1'b0;
  endtask

  // pulse bits expected for a radio opcode with low nibble k
  function automatic logic [15:0] expPulse(input logic [3:0] k, input logic cca);
    logic [15:0] r;
    r = 16'h0000;
    if (k == 4'hA) r[9] = cca;
    else if ((k >= 4'h3 && k <= 4'h9) || k >= 4'hD) r[k] = 1'b1;
    return r;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic sIrq, sCmp;
    logic [7:0] x0, y0, z0, ex, ey, ez;
    logic [7:0] op;
    logic [15:0] e;
    void'($urandom(32'h5EED));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 running", running, 0);
    checkEq("R1 pc", pc, 0);
    checkEq("R1 strobe", radioStrobe, 0);
    checkEq("R1 irq/setCmp", {irq, setCmp}, 0);
    checkEq("R1 sampledCca", sampledCca, 0);
    checkEq("R1 counters", {cntX, cntY, cntZ}, 0);

    // R10 R11 immediate strobes, random opcodes and channel state
    for (int i = 0; i < 40; i++) begin
      op = 8'hE3 + 8'($urandom_range(0, 12));
      ccaIn = 1'($urandom_range(0, 1));
      hostPut(1'b1, op);
      checkEq("R10 immediate pulse", radioStrobe, expPulse(op[3:0], ccaIn));
      if (op == 8'hEB) checkEq("R11 immediate sample", sampledCca, ccaIn);
      @(negedge clk);
      checkEq("R10 pulse one cycle", radioStrobe, 0);
    end

    // R10 R11 stored radio opcodes
    for (int c = 0; c < 2; c++) begin
      ccaIn = 1'(c);
      prog[0] = 8'hD3; prog[1] = 8'hD4; prog[2] = 8'hD5; prog[3] = 8'hD6;
      prog[4] = 8'hD7; prog[5] = 8'hD8; prog[6] = 8'hD9; prog[7] = 8'hDA;
      prog[8] = 8'hDB; prog[9] = 8'hDD; prog[10] = 8'hDE; prog[11] = 8'hDF;
      loadAndStart(12);
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        checkEq("R10 stored pulse", radioStrobe, expPulse(prog[i][3:0], ccaIn));
      end
      checkEq("R11 stored sample", sampledCca, ccaIn);
      checkEq("R3 ends at write pointer", {running, pc}, 12);
    end
    ccaIn = 1'b0;

    // R4 R5 random counter programs checked against a bench model
    for (int t = 0; t < 6; t++) begin
      ex = cntX; ey = cntY; ez = cntZ;
      for (int i = 0; i < 16; i++) begin
        op = ($urandom_range(0, 3) == 0) ? (8'hC8 | 8'($urandom_range(0, 7)))
                                         : (8'hC0 + 8'($urandom_range(0, 5)));
        prog[i] = op;
        case (op)
          8'hC0: ex = ex + 8'd1;
          8'hC1: ey = ey + 8'd1;
          8'hC2: ez = ez + 8'd1;
          8'hC3: ex = ex - 8'd1;
          8'hC4: ey = ey - 8'd1;
          8'hC5: ez = ez - 8'd1;
          default: if (ey < {5'd0, op[2:0]}) ey = ey + 8'd1;
        endcase
      end
      loadAndStart(16);
      runToEnd(sIrq, sCmp);
      checkEq("R4 X", cntX, ex);
      checkEq("R5 Y", cntY, ey);
      checkEq("R4 Z", cntZ, ez);
    end

    // R8 R5 loop Y down to zero, then bounded increments to 3
    prog[0] = 8'hBB; prog[1] = 8'hC4; prog[2] = 8'hAD;
    for (int i = 3; i < 8; i++) prog[i] = 8'hCB;
    loadAndStart(8);
    runToEnd(sIrq, sCmp);
    checkEq("R8 R5 Y after loop and capped increments", cntY, 3);
    checkEq("R8 pc at end", pc, 8);

    // R4 wrap: Z forced through zero
    z0 = cntZ;
    prog[0] = 8'hBB; prog[1] = 8'hC5; prog[2] = 8'hAE; prog[3] = 8'hC5;
    loadAndStart(4);
    runToEnd(sIrq, sCmp);
    checkEq("R4 decrement wraps to 255", cntZ, 8'hFF);

    // R5 random load, R6 wait on X
    rndIn = 8'h02;
    prog[0] = 8'hBD; prog[1] = 8'hBC; prog[2] = 8'hBA;
    loadAndStart(3);
    @(negedge clk);
    checkEq("R5 random load", cntX, 2);
    @(negedge clk);
    pulse(0);
    checkEq("R6 wait X first tick", irq, 0);
    pulse(0);
    @(negedge clk);
    checkEq("R6 wait X released", irq, 1);

    // R6 wait W=3 ticks
    prog[0] = 8'h83; prog[1] = 8'hBA;
    loadAndStart(2);
    @(negedge clk);
    checkEq("R6 stalled pc and running", {running, pc}, {1'b1, 5'd1});
    pulse(0); pulse(0); pulse(0);
    checkEq("R6 no irq before resume", irq, 0);
    @(negedge clk);
    checkEq("R6 irq after three ticks", irq, 1);

    // R6 zero count
    prog[0] = 8'h80; prog[1] = 8'hBA;
    loadAndStart(2);
    @(negedge clk);
    checkEq("R6 zero wait step", irq, 0);
    @(negedge clk);
    checkEq("R6 zero wait one cycle", irq, 1);

    // R7 event 2 wait ignores event 1
    prog[0] = 8'hB9; prog[1] = 8'hBE;
    loadAndStart(2);
    @(negedge clk);
    pulse(1);
    @(negedge clk);
    checkEq("R7 event1 ignored by ev2 wait", {setCmp, running, pc}, {2'b01, 5'd1});
    pulse(2);
    @(negedge clk);
    checkEq("R12 setCmp after event2", setCmp, 1);

    // R7 event 1 wait ignores event 2
    prog[0] = 8'hB8; prog[1] = 8'hBE;
    loadAndStart(2);
    @(negedge clk);
    pulse(2);
    @(negedge clk);
    checkEq("R7 event2 ignored by ev1 wait", setCmp, 0);
    pulse(1);
    @(negedge clk);
    checkEq("R7 R12 setCmp after event1", setCmp, 1);

    // R3 stop aborts a long wait
    prog[0] = 8'h9F; prog[1] = 8'hBA;
    loadAndStart(2);
    @(negedge clk); @(negedge clk);
    hostPut(1'b1, 8'hE2);
    checkEq("R3 stop ends run", running, 0);
    sIrq = 1'b0;
    for (int i = 0; i < 35; i++) begin pulse(0); sIrq |= irq; end
    checkEq("R3 aborted wait never resumes", {sIrq, pc}, 1);

    // R9 skip always, and inverted always (never)
    x0 = cntX; y0 = cntY;
    prog[0] = 8'h27; prog[1] = 8'hC0; prog[2] = 8'hC0; prog[3] = 8'hC1;
    loadAndStart(4);
    runToEnd(sIrq, sCmp);
    checkEq("R9 skipped X", cntX, x0);
    checkEq("R9 landed Y", cntY, y0 + 8'd1);
    x0 = cntX;
    prog[0] = 8'h2F; prog[1] = 8'hC0; prog[2] = 8'hC0;
    loadAndStart(3);
    runToEnd(sIrq, sCmp);
    checkEq("R9 inverted condition no skip", cntX, x0 + 8'd2);

    // R9 skip on channel clear
    ccaIn = 1'b1;
    prog[0] = 8'h10; prog[1] = 8'hBA;
    loadAndStart(2);
    runToEnd(sIrq, sCmp);
    checkEq("R9 skip when clear", sIrq, 0);
    ccaIn = 1'b0;
    loadAndStart(2);
    runToEnd(sIrq, sCmp);
    checkEq("R9 fall through when busy", sIrq, 1);

    // R3 halt
    prog[0] = 8'hD2; prog[1] = 8'hBA;
    loadAndStart(2);
    runToEnd(sIrq, sCmp);
    checkEq("R3 halt stops with pc on it", {sIrq, running, pc}, 0);

    // R2 capacity: 24 stored, 4 dropped
    x0 = cntX; y0 = cntY;
    for (int i = 0; i < 24; i++) prog[i] = 8'hC0;
    for (int i = 24; i < 28; i++) prog[i] = 8'hC1;
    loadAndStart(28);
    runToEnd(sIrq, sCmp);
    checkEq("R2 stored bytes ran", cntX, x0 + 8'd24);
    checkEq("R2 extra bytes dropped", cntY, y0);
    checkEq("R2 end pc", pc, 24);

    // R2 clear empties the store
    hostPut(1'b1, 8'hFF);
    checkEq("R2 clear pc", {running, pc}, 0);
    hostPut(1'b1, 8'hE1);
    checkEq("R2 empty store does not run", running, 0);

    // R13 immediate pulse merged with stored pulse
    prog[0] = 8'hD3; prog[1] = 8'hD4; prog[2] = 8'hD5;
    loadAndStart(3);
    hostPut(1'b1, 8'hEE);
    e = 16'h0000; e[3] = 1'b1; e[14] = 1'b1;
    checkEq("R13 merged pulses", radioStrobe, e);
    @(negedge clk);
    checkEq("R13 program continues", radioStrobe, 16'h0010);

    // R13 stop suppresses the instruction in its cycle
    prog[0] = 8'hD3; prog[1] = 8'hD4;
    loadAndStart(2);
    hostPut(1'b1, 8'hE2);
    checkEq("R13 stop wins", {radioStrobe, running, pc}, 0);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule